// File: doc/BRIEF.md
# Keyboard Port Host Interface

This block is the host-side half of a 12-bit parallel link to an intelligent keyboard. Twelve lines carry data from the keyboard: an 8-bit key code and four modifier flags. Eight of those lines also carry LED control data back to the keyboard. A single active-low strobe from the keyboard does two jobs. When no LED write is outstanding, it announces a new key. When an LED write is outstanding, it confirms that the keyboard took the write.

On a key event the block latches the whole 12-bit word. It then raises an interrupt to the CPU and pulls the host acknowledge line low, which tells the keyboard it must not send again yet. A one-cycle read pulse from the CPU takes the word, drops the interrupt and releases acknowledge.

On a CPU write, the block drives the LED byte onto the shared lines and pulls the LED strobe low. It then waits for the keyboard's strobe. That strobe is consumed internally and never reaches the CPU as an interrupt. After the acceptance, a busy flag stays up for a programmable guard time, so that LED writes cannot come closer together than the keyboard can take them.

Top module: `kbd_port_host`

## Requirements
- R1: After a synchronous reset: cpu_irq is 0, kb_ack_n is 1, kb_led_strobe_n is 1, kb_data_oe is 0, cpu_busy is 0 and cpu_key_word is 0.
- R2: When kb_strobe_n falls with no LED write pending, the block captures kb_data_i into cpu_key_word. Bits 7:0 hold the key code, bit 8 SHIFT, bit 9 CTRL, bit 10 M1 and bit 11 M2, all active high. In the same update it sets cpu_irq to 1 and kb_ack_n to 0. This takes effect on the third rising edge at which the low strobe is present, and not before.
- R3: A one-cycle cpu_rd pulse clears cpu_irq and sets kb_ack_n to 1 at the next edge, and leaves cpu_key_word unchanged.
- R4: If a new key event and cpu_rd fall in the same cycle, the key event wins: cpu_irq stays 1, kb_ack_n stays 0 and cpu_key_word takes the new word.
- R5: A cpu_wr pulse while cpu_busy is 0 drives cpu_wdata onto kb_data_o, sets kb_data_oe to 1, pulls kb_led_strobe_n low and sets cpu_busy, all at the next edge. The byte holds the LED select code in bits 4:0 and the on/off state in bit 7.
- R6: A falling kb_strobe_n while an LED write is pending is taken as acceptance, with the same three-edge latency as R2. kb_led_strobe_n returns high and kb_data_oe drops to 0. cpu_irq, kb_ack_n and cpu_key_word do not change.
- R7: A cpu_wr while cpu_busy is 1 is ignored: kb_data_o keeps the pending byte, and no new LED strobe follows.
- R8: After an acceptance, cpu_busy stays 1 for exactly GAP_CYC clock cycles and then clears. A key strobe during this guard time is a normal key event.
- R9: kb_data_oe is 1 exactly while kb_led_strobe_n is 0. The shared lines are otherwise released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kb_strobe_n | input | 1 | Asynchronous strobe from the keyboard, active low |
| kb_data_i | input | 12 | Keyboard bus as seen by the host |
| kb_data_o | output | 8 | LED byte driven onto the shared lines |
| kb_data_oe | output | 1 | Drive enable for the shared lines |
| kb_ack_n | output | 1 | Host acknowledge, low while a key word is untaken |
| kb_led_strobe_n | output | 1 | LED write strobe, active low |
| cpu_rd | input | 1 | One-cycle read of the key word |
| cpu_wr | input | 1 | One-cycle LED write request |
| cpu_wdata | input | 8 | LED byte from the CPU |
| cpu_key_word | output | 12 | Latched key code and modifiers |
| cpu_irq | output | 1 | Key interrupt, high until read |
| cpu_busy | output | 1 | LED write outstanding or in its guard time |

## Verification
The bench builds the block with GAP_CYC set to 40 and leaves the other parameters at their defaults. The short guard time lets the bench walk the whole busy window edge by edge and observe the exact cycle in which busy clears. It also lets the bench try a write inside that window and then confirm that no strobe follows it. Keeping two synchronizer stages fixes the strobe latency at three edges, so the bench can place a read pulse in the same cycle as a key event to test which one wins.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/kbd_sync_fall.sv
module kbd_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/kbd_rx.sv
module kbd_rx #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_ev,
  input  logic              cpu_rd,
  input  logic [WORD_W-1:0] data_in,
  output logic              irq,
  output logic              ack_n,
  output logic [WORD_W-1:0] key_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      ack_n    <= 1'b1;
      key_word <= '0;
    end else if (key_ev) begin
      key_word <= data_in;
      irq      <= 1'b1;
      ack_n    <= 1'b0;
    end else if (cpu_rd) begin
      irq      <= 1'b0;
      ack_n    <= 1'b1;
    end
  end

  // R2: a key event latches the bus word and raises the interrupt
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    key_ev |=> (irq && !ack_n && key_word == $past(data_in)));

  // R3: a read with no competing key event releases the handshake
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !key_ev) |=> (!irq && ack_n && $stable(key_word)));

  // R4: a key event in the same cycle as a read keeps the interrupt
  a_r4_key_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && key_ev) |=> irq);
endmodule

// File: rtl/kbd_tx.sv
module kbd_tx
  import kbd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GAP_CYC = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept_ev,
  output logic              led_strobe_n,
  output logic              drive_en,
  output logic [DATA_W-1:0] drive_data,
  output logic              busy,
  output logic              pending
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);

  tx_state_t         state;
  logic [CNT_W-1:0]  gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= TX_IDLE;
      gap_cnt      <= '0;
      led_strobe_n <= 1'b1;
      drive_en     <= 1'b0;
      drive_data   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (cpu_wr) begin
            drive_data   <= wdata;
            led_strobe_n <= 1'b0;
            drive_en     <= 1'b1;
            state        <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (accept_ev) begin
            led_strobe_n <= 1'b1;
            drive_en     <= 1'b0;
            gap_cnt      <= CNT_W'(GAP_CYC);
            state        <= TX_GAP;
          end
        end
        TX_GAP: begin
          if (gap_cnt == CNT_W'(1)) begin
            state <= TX_IDLE;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy    = (state != TX_IDLE);
  assign pending = (state == TX_WAIT);

  // R7: a write while busy leaves the driven byte alone
  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_wr) |=> $stable(drive_data));

  // R7: a write during the guard time starts no strobe
  a_r7_no_strobe_in_gap: assert property (@(posedge clk) disable iff (rst)
    (state == TX_GAP && cpu_wr) |=> led_strobe_n);

  // R6: acceptance releases the strobe and the lines, busy stays up
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (pending && accept_ev) |=> (led_strobe_n && !drive_en && busy));
endmodule

// File: rtl/kbd_port_host.sv
module kbd_port_host #(
  parameter int CODE_W      = 8,
  parameter int MOD_W       = 4,
  parameter int LED_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYC     = 25000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    kb_strobe_n,
  input  logic [CODE_W+MOD_W-1:0] kb_data_i,
  output logic [LED_W-1:0]        kb_data_o,
  output logic                    kb_data_oe,
  output logic                    kb_ack_n,
  output logic                    kb_led_strobe_n,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [LED_W-1:0]        cpu_wdata,
  output logic [CODE_W+MOD_W-1:0] cpu_key_word,
  output logic                    cpu_irq,
  output logic                    cpu_busy
);
  localparam int WORD_W = CODE_W + MOD_W;

  logic fall;
  logic pending;
  logic key_ev;
  logic accept_ev;

  kbd_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (kb_strobe_n),
    .fall    (fall)
  );

  assign key_ev    = fall & ~pending;
  assign accept_ev = fall & pending;

  kbd_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .key_ev   (key_ev),
    .cpu_rd   (cpu_rd),
    .data_in  (kb_data_i),
    .irq      (cpu_irq),
    .ack_n    (kb_ack_n),
    .key_word (cpu_key_word)
  );

  kbd_tx #(.DATA_W(LED_W), .GAP_CYC(GAP_CYC)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .wdata        (cpu_wdata),
    .accept_ev    (accept_ev),
    .led_strobe_n (kb_led_strobe_n),
    .drive_en     (kb_data_oe),
    .drive_data   (kb_data_o),
    .busy         (cpu_busy),
    .pending      (pending)
  );

  // R6: an acceptance strobe never turns into a CPU interrupt
  a_r6_ack_silent: assert property (@(posedge clk) disable iff (rst)
    (accept_ev && !cpu_irq && !cpu_rd) |=> !cpu_irq);
endmodule

// File: tb/kbd_port_host_tb_top.sv
module kbd_port_host_tb_top;
  localparam int GAP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kb_strobe_n = 1'b1;
  logic [11:0] kb_data_i = '0;
  logic [7:0]  kb_data_o;
  logic        kb_data_oe;
  logic        kb_ack_n;
  logic        kb_led_strobe_n;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [11:0] cpu_key_word;
  logic        cpu_irq;
  logic        cpu_busy;

  int          checks = 0;
  int          failures = 0;
  logic [11:0] exp_q[$];
  logic        irq_prev = 1'b0;

  always #2 clk = ~clk;

  kbd_port_host #(.GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst(rst), .kb_strobe_n(kb_strobe_n), .kb_data_i(kb_data_i),
    .kb_data_o(kb_data_o), .kb_data_oe(kb_data_oe), .kb_ack_n(kb_ack_n),
    .kb_led_strobe_n(kb_led_strobe_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_key_word(cpu_key_word), .cpu_irq(cpu_irq),
    .cpu_busy(cpu_busy)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key_press(input logic [11:0] w);
    kb_data_i   = w;
    kb_strobe_n = 1'b0;
    exp_q.push_back(w);
    tick(5);
    kb_strobe_n = 1'b1;
    tick(3);
  endtask

  task automatic cpu_read();
    cpu_rd = 1'b1;
    tick(1);
    cpu_rd = 1'b0;
    tick(1);
  endtask

  task automatic cpu_write(input logic [7:0] b);
    cpu_wdata = b;
    cpu_wr    = 1'b1;
    tick(1);
    cpu_wr    = 1'b0;
  endtask

  // scoreboard monitor: every rising interrupt must match the oldest expected word
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cpu_irq && !irq_prev) begin
          if (exp_q.size() == 0) begin
            check("R6", "unexpected interrupt", 32'(cpu_irq), 32'd0);
          end else begin
            check("R2", "scoreboard key word", 32'(cpu_key_word), 32'(exp_q.pop_front()));
          end
        end
        irq_prev = cpu_irq;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1", "irq", 32'(cpu_irq), 32'd0);
    check("R1", "ack_n", 32'(kb_ack_n), 32'd1);
    check("R1", "led_strobe_n", 32'(kb_led_strobe_n), 32'd1);
    check("R1", "oe", 32'(kb_data_oe), 32'd0);
    check("R1", "busy", 32'(cpu_busy), 32'd0);
    check("R1", "key_word", 32'(cpu_key_word), 32'd0);

    // R2 latency and capture: M2 + SHIFT, code 0x41
    kb_data_i   = 12'h941;
    kb_strobe_n = 1'b0;
    exp_q.push_back(12'h941);
    tick(2);
    check("R2", "irq before third edge", 32'(cpu_irq), 32'd0);
    tick(1);
    check("R2", "irq", 32'(cpu_irq), 32'd1);
    check("R2", "ack_n", 32'(kb_ack_n), 32'd0);
    check("R2", "key_word", 32'(cpu_key_word), 32'h941);
    tick(3);
    kb_strobe_n = 1'b1;
    tick(3);

    // R3 read
    cpu_rd = 1'b1;
    tick(1);
    cpu_rd = 1'b0;
    check("R3", "irq", 32'(cpu_irq), 32'd0);
    check("R3", "ack_n", 32'(kb_ack_n), 32'd1);
    check("R3", "key_word kept", 32'(cpu_key_word), 32'h941);
    tick(1);

    // R2 more patterns: CTRL, M1, all ones, all zeros
    key_press(12'h203); cpu_read();
    key_press(12'h47A); cpu_read();
    key_press(12'hFFF); cpu_read();
    key_press(12'h000); cpu_read();
    check("R2", "modifiers after all-zero word", 32'(cpu_key_word), 32'h000);

    // R4 key event and read in the same cycle
    key_press(12'h155);
    kb_data_i   = 12'h8C2;
    kb_strobe_n = 1'b0;
    tick(2);
    cpu_rd = 1'b1;
    tick(1);
    cpu_rd = 1'b0;
    check("R4", "irq kept", 32'(cpu_irq), 32'd1);
    check("R4", "ack_n low", 32'(kb_ack_n), 32'd0);
    check("R4", "new word", 32'(cpu_key_word), 32'h8C2);
    kb_strobe_n = 1'b1;
    tick(3);
    cpu_read();

    // R5 LED write: select 0x05, on
    cpu_write(8'h85);
    check("R5", "led_strobe_n", 32'(kb_led_strobe_n), 32'd0);
    check("R5", "oe", 32'(kb_data_oe), 32'd1);
    check("R5", "data", 32'(kb_data_o), 32'h85);
    check("R5", "busy", 32'(cpu_busy), 32'd1);
    check("R9", "oe with strobe low", 32'(kb_data_oe), 32'(!kb_led_strobe_n));
    tick(2);

    // R7 write while pending is ignored
    cpu_write(8'h1F);
    tick(1);
    check("R7", "data kept while pending", 32'(kb_data_o), 32'h85);

    // R6 acceptance strobe
    kb_data_i   = 12'h7E7;
    kb_strobe_n = 1'b0;
    tick(3);
    check("R6", "led_strobe_n released", 32'(kb_led_strobe_n), 32'd1);
    check("R6", "oe released", 32'(kb_data_oe), 32'd0);
    check("R6", "no irq", 32'(cpu_irq), 32'd0);
    check("R6", "ack_n unchanged", 32'(kb_ack_n), 32'd1);
    check("R6", "key_word unchanged", 32'(cpu_key_word), 32'h8C2);
    check("R8", "busy at acceptance", 32'(cpu_busy), 32'd1);

    // R8 guard window, with a write attempt inside it (R7)
    kb_strobe_n = 1'b1;
    cpu_wdata   = 8'h01;
    cpu_wr      = 1'b1;
    tick(1);
    cpu_wr = 1'b0;
    check("R7", "no strobe from gap write", 32'(kb_led_strobe_n), 32'd1);
    tick(GAP - 2);
    check("R8", "busy at last guard cycle", 32'(cpu_busy), 32'd1);
    tick(1);
    check("R8", "busy cleared", 32'(cpu_busy), 32'd0);
    check("R7", "still no strobe after gap", 32'(kb_led_strobe_n), 32'd1);
    check("R9", "lines released", 32'(kb_data_oe), 32'd0);

    // R5 new write after guard, then acceptance, then key in guard window (R8)
    cpu_write(8'h1F);
    check("R5", "second write data", 32'(kb_data_o), 32'h1F);
    check("R9", "oe follows strobe", 32'(kb_data_oe), 32'd1);
    tick(2);
    kb_strobe_n = 1'b0;
    tick(4);
    kb_strobe_n = 1'b1;
    tick(3);
    check("R6", "second acceptance no irq", 32'(cpu_irq), 32'd0);
    check("R8", "busy in guard", 32'(cpu_busy), 32'd1);
    key_press(12'h530);
    check("R8", "key in guard raises irq", 32'(cpu_irq), 32'd1);
    cpu_read();

    check("R2", "all expected keys seen", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule